// File: doc/BRIEF.md
# Three-Stage Forwarding ALU Pipeline

This block is a register-to-register arithmetic pipeline with three stages. In the first stage it accepts one instruction per clock. An instruction has two source register addresses, a destination register address and a 3-bit operation code. In the same stage it captures both operands. In the second stage it computes the result. In the third stage it writes that result into an internal register file. A stall input stops anything from entering on that cycle. A bubble marker then travels down the stages in place of an instruction, so the empty slot never writes anything.

Operands are captured from the values that will exist after the current edge. If the instruction now in the execute stage targets a source register, the operand takes the ALU output being formed this cycle. Otherwise the operand is read from the register file with the write-back of this cycle already applied. As a result, a consumer issued one or two slots behind its producer gets the correct value with no lost cycles. Each write-back is also driven out on a port triple, so the surrounding logic can observe the architectural effect of every instruction.

Top module: `alu_pipe3`

## Requirements
- R1: While reset is held, and on the first cycle after it, no write-back is reported (`wb_valid_o` is 0), because reset marks both internal stages as bubbles.
- R2: A cycle with `stall_i` high issues nothing: two edges later `wb_valid_o` is 0 for that slot.
- R3: Operation codes map as follows. 0 is a+b, 1 is a-b, 2 is a AND b, 3 is a OR b, 4 is a XOR b, 5 is a+1, 6 is a shifted left by one bit, and 7 passes a. Here a is the register at `src_a_i` and b the register at `src_b_i`. Every result wraps to DW bits.
- R4: An instruction issued on the cycle right after its producer, reading the producer's destination, receives the producer's result with no stall.
- R5: An instruction issued two cycles after its producer receives the producer's result through the same-cycle write bypass, unless the instruction in between wrote that same register.
- R6: An instruction issued on the edge where `stall_i` is low appears on `wb_valid_o`/`wb_dst_o`/`wb_data_o` after exactly two edges. The register file is updated at the third edge.
- R7: After any instruction stream followed by two stall cycles, the register contents equal those of a sequential machine that applies one instruction per issued slot.
- R8: Reset clears every register to zero.
- R9: When the execute stage holds a bubble, or the instruction is three or more slots behind any writer, operands come from the register file. A stale destination left in a bubble slot is never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | High: issue nothing this cycle |
| op_i | input | 3 | Operation code (see R3) |
| src_a_i | input | AW | First source register address |
| src_b_i | input | AW | Second source register address |
| dst_i | input | AW | Destination register address |
| wb_valid_o | output | 1 | Write-back stage holds a real instruction |
| wb_dst_o | output | AW | Register written at the next edge |
| wb_data_o | output | DW | Value written at the next edge |

## Verification
The bench builds the block with four registers and an 8-bit datapath. With only four registers, random streams produce back-to-back and two-apart hazards in most slots, and they also produce cases where a bubble slot carries a stale matching destination. With 8 bits, additions, subtractions and shifts wrap often, which exercises the DW-bit truncation. Directed chains at distances one, two and three cover each forwarding path on its own. A drain of two stall cycles then exposes the final register state.

// File: rtl/alu_pipe3.sv
module alu_pipe3 #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] src_a_i,
  input  logic [AW-1:0] src_b_i,
  input  logic [AW-1:0] dst_i,
  output logic          wb_valid_o,
  output logic [AW-1:0] wb_dst_o,
  output logic [DW-1:0] wb_data_o
);

  logic [DW-1:0] rf [NREG];

  logic          ex_bub;
  logic [2:0]    ex_op;
  logic [AW-1:0] ex_dst;
  logic [DW-1:0] ex_a, ex_b;

  logic          wb_bub;
  logic [AW-1:0] wb_dst;
  logic [DW-1:0] wb_res;

  function automatic logic [DW-1:0] alu(input logic [2:0] op,
                                        input logic [DW-1:0] a,
                                        input logic [DW-1:0] b);
    case (op)
      3'd0:    alu = a + b;
      3'd1:    alu = a - b;
      3'd2:    alu = a & b;
      3'd3:    alu = a | b;
      3'd4:    alu = a ^ b;
      3'd5:    alu = a + DW'(1);
      3'd6:    alu = {a[DW-2:0], 1'b0};
      default: alu = a;
    endcase
  endfunction

  logic [DW-1:0] ex_res;
  assign ex_res = alu(ex_op, ex_a, ex_b);

  function automatic logic [DW-1:0] operand(input logic [AW-1:0] src);
    if (!ex_bub && ex_dst == src)
      operand = ex_res;
    else if (!wb_bub && wb_dst == src)
      operand = wb_res;
    else
      operand = rf[src];
  endfunction

  logic [DW-1:0] next_a, next_b;
  assign next_a = operand(src_a_i);
  assign next_b = operand(src_b_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_bub <= 1'b1;
      wb_bub <= 1'b1;
      ex_op  <= '0;
      ex_dst <= '0;
      ex_a   <= '0;
      ex_b   <= '0;
      wb_dst <= '0;
      wb_res <= '0;
    end else begin
      ex_bub <= stall_i;
      ex_op  <= op_i;
      ex_dst <= dst_i;
      ex_a   <= next_a;
      ex_b   <= next_b;
      wb_bub <= ex_bub;
      wb_dst <= ex_dst;
      wb_res <= ex_res;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (!wb_bub) begin
      rf[wb_dst] <= wb_res;
    end
  end

  assign wb_valid_o = !wb_bub;
  assign wb_dst_o   = wb_dst;
  assign wb_data_o  = wb_res;

endmodule

// File: rtl/alu_pipe3_chk.sv
module alu_pipe3_chk #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall_i,
  input logic [2:0]    op_i,
  input logic [AW-1:0] src_a_i,
  input logic [AW-1:0] dst_i,
  input logic          wb_valid_o,
  input logic [AW-1:0] wb_dst_o,
  input logic [DW-1:0] wb_data_o
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !wb_valid_o);

  assert_stall_bubble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> ##2 !wb_valid_o);

  assert_issue_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_i |-> ##2 (wb_valid_o && wb_dst_o == $past(dst_i, 2)));

  assert_forward_near_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && op_i == 3'd7 && $past(rst_n) && !$past(stall_i) &&
     src_a_i == $past(dst_i))
    |-> ##2 (wb_data_o == $past(wb_data_o)));

  assert_forward_far_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && op_i == 3'd7 && $past(rst_n, 2) && !$past(stall_i, 2) &&
     src_a_i == $past(dst_i, 2) &&
     ($past(stall_i) || src_a_i != $past(dst_i)))
    |-> ##2 (wb_data_o == $past(wb_data_o, 2)));

endmodule

bind alu_pipe3 alu_pipe3_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .op_i(op_i),
  .src_a_i(src_a_i), .dst_i(dst_i), .wb_valid_o(wb_valid_o),
  .wb_dst_o(wb_dst_o), .wb_data_o(wb_data_o)
);

// File: tb/alu_pipe3_bench.sv
module alu_pipe3_bench;
  localparam int NREG = 4;
  localparam int DW   = 8;
  localparam int AW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall_i = 1'b1;
  logic [2:0]    op_i = '0;
  logic [AW-1:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic          wb_valid_o;
  logic [AW-1:0] wb_dst_o;
  logic [DW-1:0] wb_data_o;

  alu_pipe3 #(.NREG(NREG), .DW(DW), .AW(AW)) u_alu_pipe3 (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .op_i(op_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
    .wb_valid_o(wb_valid_o), .wb_dst_o(wb_dst_o), .wb_data_o(wb_data_o)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [DW-1:0] ref_rf [NREG];
  logic [DW-1:0] seen_rf [NREG];

  logic          p_valid;
  logic [AW-1:0] p_dst;
  logic [DW-1:0] p_data;
  string         p_tag;

  function automatic logic [DW-1:0] ref_alu(input logic [2:0] op,
                                            input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a + 8'd1;
      3'd6: return a << 1;
      default: return a;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit st, input logic [2:0] op, input logic [AW-1:0] a,
                      input logic [AW-1:0] b, input logic [AW-1:0] d, input string tag);
    logic          c_valid;
    logic [DW-1:0] c_data;
    stall_i = st; op_i = op; src_a_i = a; src_b_i = b; dst_i = d;
    c_valid = !st;
    c_data = ref_alu(op, ref_rf[a], ref_rf[b]);
    if (c_valid) ref_rf[d] = c_data;
    @(posedge clk);
    @(negedge clk);
    check(wb_valid_o == p_valid, p_valid ? "R6 valid" : "R2 bubble",
          int'(wb_valid_o), int'(p_valid));
    if (p_valid) begin
      check(wb_dst_o == p_dst, {"R6 dst ", p_tag}, int'(wb_dst_o), int'(p_dst));
      check(wb_data_o == p_data, {"R3 data ", p_tag}, int'(wb_data_o), int'(p_data));
    end
    if (wb_valid_o) seen_rf[wb_dst_o] = wb_data_o;
    p_valid = c_valid; p_dst = d; p_data = c_data; p_tag = tag;
  endtask

  task automatic drain_and_compare(input string tag);
    step(1'b1, 3'd0, '0, '0, '0, "drain");
    step(1'b1, 3'd0, '0, '0, '0, "drain");
    for (int i = 0; i < NREG; i++)
      check(seen_rf[i] == ref_rf[i], {"R7 state ", tag}, int'(seen_rf[i]), int'(ref_rf[i]));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < NREG; i++) begin ref_rf[i] = '0; seen_rf[i] = '0; end
    p_valid = 1'b0; p_dst = '0; p_data = '0; p_tag = "";
    repeat (3) @(negedge clk);
    check(wb_valid_o == 1'b0, "R1 in reset", int'(wb_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wb_valid_o == 1'b0, "R1 after reset", int'(wb_valid_o), 0);

    // R8: registers read as zero after reset
    step(1'b0, 3'd3, 2'd1, 2'd2, 2'd0, "R8 zero");
    step(1'b0, 3'd7, 2'd3, 2'd3, 2'd3, "R8 zero");

    // R4: chain at distance one
    step(1'b0, 3'd5, 2'd0, 2'd0, 2'd1, "R4 inc");
    step(1'b0, 3'd5, 2'd1, 2'd1, 2'd1, "R4 inc");
    step(1'b0, 3'd0, 2'd1, 2'd1, 2'd2, "R4 add same src");
    step(1'b0, 3'd6, 2'd2, 2'd0, 2'd2, "R4 shift");

    // R5: distance two, and a middle writer to the same register
    step(1'b0, 3'd5, 2'd2, 2'd0, 2'd3, "R5 prod");
    step(1'b0, 3'd4, 2'd1, 2'd2, 2'd0, "R5 mid");
    step(1'b0, 3'd1, 2'd3, 2'd1, 2'd1, "R5 cons");
    step(1'b0, 3'd5, 2'd0, 2'd0, 2'd2, "R5 prod2");
    step(1'b0, 3'd5, 2'd0, 2'd0, 2'd2, "R5 overwrite");
    step(1'b0, 3'd7, 2'd2, 2'd0, 2'd3, "R5 youngest");

    // R9: stale destination in bubble slot, distance three
    step(1'b0, 3'd6, 2'd3, 2'd0, 2'd0, "R9 prod");
    step(1'b1, 3'd0, 2'd0, 2'd0, 2'd0, "R2 stall");
    step(1'b1, 3'd0, 2'd0, 2'd0, 2'd0, "R2 stall");
    step(1'b0, 3'd2, 2'd0, 2'd3, 2'd1, "R9 dist3");
    step(1'b1, 3'd5, 2'd1, 2'd1, 2'd1, "R2 stalled op");
    step(1'b0, 3'd7, 2'd1, 2'd1, 2'd2, "R9 bubble");
    drain_and_compare("directed");

    // R3: every opcode, random mix with stalls
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 4) == 0, 3'($urandom), AW'($urandom), AW'($urandom),
           AW'($urandom), "random");
      if (n % 1000 == 999) drain_and_compare("random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule